// File: doc/BRIEF.md
# Parallel Master Bus Interface

This block lets an on-chip host run read and write transfers on an external 8-bit parallel bus, reaching memories, peripherals or slave controllers. The host presents one request at a time: a direction, a 16-bit address (or a request to reuse the internal address pointer), write data, and a configuration. The configuration sets the strobe style, the data width, the address multiplexing mode, the active level of each control output, the pointer step, and whether the two top address bits act as chip selects. The block then walks through its bus phases, one clock per phase, and reports completion with a single-cycle done pulse, along with the read data for reads.

Address phases come first and depend on the multiplexing mode. Data phases follow: one byte for 8-bit transfers, and two for 16-bit transfers. In a 16-bit transfer the low byte goes first and the byte-enable strobe marks the high byte. Every bus-side output comes straight from a flip-flop. Direction, width, mode, strobe style, step and chip-select usage are captured when a request is accepted. The active levels are applied live.

Top module: `pbus_master`

## Requirements
- R1: While reset is high and after it is released with no request, busy, done, bus_oe, bus_dout, bus_addr and rd_data are zero, and every control pin sits at its inactive level, which is the inverse of its polarity bit.
- R2: With cfg_mux 00, and with the reserved code 11 (handled the same as 00), there are no address phases. bus_addr carries the full output address during every phase, and each data byte takes exactly one cycle.
- R3: With cfg_mux 01, one address phase comes before the data. In it, bus_dout carries the low address byte with the low latch strobe active. Throughout the transfer bus_addr carries the high address byte in bits 15:8 and zero in bits 7:0.
- R4: With cfg_mux 10, two address phases come before the data. The first carries the low address byte with the low latch strobe active. The second carries the high address byte with the high latch strobe active. bus_addr stays zero, and the two latch strobes are never active together.
- R5: With cfg_wide set, there are two data phases: low byte first, then high byte. bus_be is active only in the high-byte phase.
- R6: With cfg_sep_strobes set, bus_rd is active only in the data phases of a read and bus_wr only in the data phases of a write.
- R7: With cfg_sep_strobes clear, bus_rd is the direction line and is active in every phase of a read. bus_wr is the enable line and is active in every data phase.
- R8: Each control pin equals its polarity bit when active and the inverse when inactive. The polarity bits are: cfg_pol[0] bus_rd, [1] bus_wr, [2] bus_be, [3] both latch strobes, [4] bus_cs1, [5] bus_cs2.
- R9: cfg_cs_en[0] makes address bit 14 drive bus_cs1, and cfg_cs_en[1] makes bit 15 drive bus_cs2, active during the whole transfer. An enabled bit is forced to 0 in both bus_addr and the multiplexed address bytes.
- R10: With req_use_addr set the pointer loads req_addr. Otherwise the transfer uses the pointer as it stands. After each transfer the pointer changes according to cfg_step: 01 adds one, 10 subtracts one (both wrap at 16 bits), and 00 or 11 leave it unchanged.
- R11: bus_oe is high in address phases and write data phases, and low in read data phases and when idle. bus_dout is zero when bus_oe is low.
- R12: busy is high from the cycle after acceptance through the last phase. done pulses in the next cycle. rd_data holds the bytes sampled from bus_din on the last cycle of each data phase, with the high byte zero for 8-bit reads. A req_valid seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transfer; accepted when idle |
| req_write | input | 1 | 1 write, 0 read |
| req_use_addr | input | 1 | Load req_addr into the pointer for this transfer |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data (bits 15:8 used only when wide) |
| cfg_sep_strobes | input | 1 | 1 separate read/write strobes, 0 direction plus enable |
| cfg_wide | input | 1 | 16-bit transfer in two bytes |
| cfg_mux | input | 2 | Address multiplexing mode |
| cfg_step | input | 2 | Pointer step after each transfer |
| cfg_cs_en | input | 2 | Use address bits 14/15 as chip selects 1/2 |
| cfg_pol | input | 6 | Active level of each control pin |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| bus_dout | output | 8 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | 8 | Data bus input value |
| bus_addr | output | 16 | Dedicated address lines |
| bus_rd | output | 1 | Read strobe or direction line |
| bus_wr | output | 1 | Write strobe or enable line |
| bus_be | output | 1 | High-byte flag |
| bus_all | output | 1 | Low address latch strobe |
| bus_alh | output | 1 | High address latch strobe |
| bus_cs1 | output | 1 | Chip select 1 |
| bus_cs2 | output | 1 | Chip select 2 |

## Verification
The assertions compare pin levels against cfg_pol, and they read the captured transfer configuration. They therefore assume cfg_pol is stable from acceptance until busy drops. They also assume that the host changes configuration only when the block is idle. The stimulus respects both assumptions. It changes every configuration input, including random polarities, only on the idle cycle before a request. Extra req_valid pulses are issued only while busy, so they test that requests are ignored during a transfer without violating the first assumption.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ALO  = 3'd1,
    PH_AHI  = 3'd2,
    PH_DLO  = 3'd3,
    PH_DHI  = 3'd4
  } phase_e;

  localparam logic [1:0] MUX_NONE = 2'b00;
  localparam logic [1:0] MUX_LOW  = 2'b01;
  localparam logic [1:0] MUX_FULL = 2'b10;

  localparam logic [1:0] STEP_INC = 2'b01;
  localparam logic [1:0] STEP_DEC = 2'b10;

  typedef struct packed {
    logic       sep;
    logic       wide;
    logic [1:0] mux;
    logic [1:0] step;
    logic [1:0] cs_en;
    logic       wr;
  } xfer_cfg_t;

  function automatic logic drive_pin(input logic act, input logic pol);
    return act ? pol : ~pol;
  endfunction

endpackage

// File: rtl/pbus_seq.sv
`timescale 1ns/1ps
module pbus_seq
  import pbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [1:0] mux,
  input  logic       wide,
  output phase_e     ph,
  output phase_e     ph_n,
  output logic       last
);

  always_comb begin
    ph_n = PH_IDLE;
    case (ph)
      PH_IDLE: if (go) ph_n = (mux == MUX_LOW || mux == MUX_FULL) ? PH_ALO : PH_DLO;
      PH_ALO:  ph_n = (mux == MUX_FULL) ? PH_AHI : PH_DLO;
      PH_AHI:  ph_n = PH_DLO;
      PH_DLO:  ph_n = wide ? PH_DHI : PH_IDLE;
      default: ph_n = PH_IDLE;
    endcase
  end

  assign last = (ph != PH_IDLE) && (ph_n == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IDLE;
    else     ph <= ph_n;
  end

  // R4: high address phase only directly after the low one
  p_ahi_after_alo_r4: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_AHI) |-> ($past(ph) == PH_ALO))
    else $error("high address phase out of order");

  // R5: high data byte only directly after the low byte
  p_dhi_after_dlo_r5: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DHI) |-> ($past(ph) == PH_DLO))
    else $error("high data phase out of order");

endmodule

// File: rtl/pbus_addr.sv
`timescale 1ns/1ps
module pbus_addr
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CS_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              advance,
  input  logic [1:0]        step,
  input  logic [CS_N-1:0]   cs_en,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CS_N-1:0]   cs_hit
);

  localparam int CS_BASE = ADDR_W - CS_N;

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] eff;

  assign eff = load ? load_val : ptr;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    if (g >= CS_BASE) begin : g_cs
      assign out_addr[g]          = eff[g] & ~cs_en[g-CS_BASE];
      assign cs_hit[g-CS_BASE]    = eff[g] &  cs_en[g-CS_BASE];
    end else begin : g_plain
      assign out_addr[g] = eff[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (advance) begin
      case (step)
        STEP_INC: ptr <= ptr + 1'b1;
        STEP_DEC: ptr <= ptr - 1'b1;
        default:  ptr <= ptr;
      endcase
    end else if (load) begin
      ptr <= load_val;
    end
  end

  // R10: pointer holds between transfers unless reloaded
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(advance) && !$past(load) && !$past(rst)) |-> (ptr == $past(ptr)))
    else $error("pointer moved without a transfer");

endmodule

// File: rtl/pbus_master.sv
`timescale 1ns/1ps
module pbus_master
  import pbus_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CS_N   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_use_addr,
  input  logic [2*BYTE_W-1:0] req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  input  logic                cfg_sep_strobes,
  input  logic                cfg_wide,
  input  logic [1:0]          cfg_mux,
  input  logic [1:0]          cfg_step,
  input  logic [CS_N-1:0]     cfg_cs_en,
  input  logic [5:0]          cfg_pol,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0]   bus_dout,
  output logic                bus_oe,
  input  logic [BYTE_W-1:0]   bus_din,
  output logic [2*BYTE_W-1:0] bus_addr,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic                bus_be,
  output logic                bus_all,
  output logic                bus_alh,
  output logic                bus_cs1,
  output logic                bus_cs2
);

  localparam int ADDR_W = 2 * BYTE_W;
  localparam int WORD_W = 2 * BYTE_W;

  phase_e            ph, ph_n;
  logic              last, accept;
  xfer_cfg_t         live_cfg, cfg_q, cur;
  logic [WORD_W-1:0] wd_q, wd_cur;
  logic [ADDR_W-1:0] m_addr;
  logic [CS_N-1:0]   cs_hit;

  assign accept   = req_valid && (ph == PH_IDLE);
  assign live_cfg = '{sep: cfg_sep_strobes, wide: cfg_wide, mux: cfg_mux,
                      step: cfg_step, cs_en: cfg_cs_en, wr: req_write};
  assign cur      = accept ? live_cfg : cfg_q;
  assign wd_cur   = accept ? req_wdata : wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      wd_q  <= '0;
    end else if (accept) begin
      cfg_q <= live_cfg;
      wd_q  <= req_wdata;
    end
  end

  pbus_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .go   (accept),
    .mux  (cur.mux),
    .wide (cur.wide),
    .ph   (ph),
    .ph_n (ph_n),
    .last (last)
  );

  pbus_addr #(.ADDR_W(ADDR_W), .CS_N(CS_N)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept && req_use_addr),
    .load_val (req_addr),
    .advance  (last),
    .step     (cfg_q.step),
    .cs_en    (cur.cs_en),
    .out_addr (m_addr),
    .cs_hit   (cs_hit)
  );

  // next-cycle pin values, decoded from the next phase
  logic              in_x, dph;
  logic              a_rd, a_wr, a_be, a_all, a_alh;
  logic [CS_N-1:0]   a_cs;
  logic [BYTE_W-1:0] dout_n;
  logic              oe_n;
  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    in_x  = (ph_n != PH_IDLE);
    dph   = (ph_n == PH_DLO) || (ph_n == PH_DHI);
    a_rd  = cur.sep ? (dph && !cur.wr) : (in_x && !cur.wr);
    a_wr  = cur.sep ? (dph && cur.wr) : dph;
    a_be  = (ph_n == PH_DHI);
    a_all = (ph_n == PH_ALO);
    a_alh = (ph_n == PH_AHI);
    a_cs  = in_x ? cs_hit : '0;
    dout_n = '0;
    oe_n   = 1'b0;
    case (ph_n)
      PH_ALO: begin dout_n = m_addr[BYTE_W-1:0];      oe_n = 1'b1; end
      PH_AHI: begin dout_n = m_addr[ADDR_W-1:BYTE_W]; oe_n = 1'b1; end
      PH_DLO: if (cur.wr) begin dout_n = wd_cur[BYTE_W-1:0];      oe_n = 1'b1; end
      PH_DHI: if (cur.wr) begin dout_n = wd_cur[WORD_W-1:BYTE_W]; oe_n = 1'b1; end
      default: ;
    endcase
    if (!in_x)                     addr_n = '0;
    else if (cur.mux == MUX_LOW)   addr_n = {m_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    else if (cur.mux == MUX_FULL)  addr_n = '0;
    else                           addr_n = m_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd   <= drive_pin(1'b0, cfg_pol[0]);
      bus_wr   <= drive_pin(1'b0, cfg_pol[1]);
      bus_be   <= drive_pin(1'b0, cfg_pol[2]);
      bus_all  <= drive_pin(1'b0, cfg_pol[3]);
      bus_alh  <= drive_pin(1'b0, cfg_pol[3]);
      bus_cs1  <= drive_pin(1'b0, cfg_pol[4]);
      bus_cs2  <= drive_pin(1'b0, cfg_pol[5]);
      bus_dout <= '0;
      bus_oe   <= 1'b0;
      bus_addr <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
    end else begin
      bus_rd   <= drive_pin(a_rd,    cfg_pol[0]);
      bus_wr   <= drive_pin(a_wr,    cfg_pol[1]);
      bus_be   <= drive_pin(a_be,    cfg_pol[2]);
      bus_all  <= drive_pin(a_all,   cfg_pol[3]);
      bus_alh  <= drive_pin(a_alh,   cfg_pol[3]);
      bus_cs1  <= drive_pin(a_cs[0], cfg_pol[4]);
      bus_cs2  <= drive_pin(a_cs[1], cfg_pol[5]);
      bus_dout <= dout_n;
      bus_oe   <= oe_n;
      bus_addr <= addr_n;
      busy     <= in_x;
      done     <= last;
      if (accept)
        rd_data <= '0;
      else if (ph == PH_DLO && !cfg_q.wr)
        rd_data[BYTE_W-1:0] <= bus_din;
      else if (ph == PH_DHI && !cfg_q.wr)
        rd_data[WORD_W-1:BYTE_W] <= bus_din;
    end
  end

  // R11: bus released while the external device drives read data
  p_oe_released_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && !cfg_q.wr && (ph == PH_DLO || ph == PH_DHI)) |-> !bus_oe)
    else $error("bus driven during read data phase");

  // R4: latch strobes never active together
  p_latch_excl_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !((bus_all == cfg_pol[3]) && (bus_alh == cfg_pol[3])))
    else $error("both latch strobes active");

  // R5: byte-enable only with the high byte
  p_be_high_only_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && ph != PH_DHI) |-> (bus_be != cfg_pol[2]))
    else $error("byte-enable outside high byte phase");

  // R9: chip-select address bit forced low on the address lines
  p_cs_bit_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_q.cs_en[1]) |-> (bus_addr[ADDR_W-1] == 1'b0))
    else $error("chip-select bit leaked onto address");

  // R12: done follows the last busy cycle
  p_done_after_busy_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)))
    else $error("done without preceding transfer");

  // R12: busy ends only with a done pulse
  p_busy_end_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done)
    else $error("busy dropped without done");

endmodule

// File: tb/pbus_master_tb.sv
`timescale 1ns/1ps
module pbus_master_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_use_addr;
  logic [15:0] req_addr, req_wdata;
  logic        c_sep, c_wide;
  logic [1:0]  c_mux, c_step, c_cs;
  logic [5:0]  c_pol;
  logic        busy, done;
  logic [15:0] rd_data;
  logic [7:0]  bus_dout, bus_din;
  logic        bus_oe;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr, bus_be, bus_all, bus_alh, bus_cs1, bus_cs2;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] ptr_m;

  always #2.5 clk = ~clk;

  pbus_master dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_use_addr(req_use_addr), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_sep_strobes(c_sep), .cfg_wide(c_wide), .cfg_mux(c_mux),
    .cfg_step(c_step), .cfg_cs_en(c_cs), .cfg_pol(c_pol),
    .busy(busy), .done(done), .rd_data(rd_data),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be), .bus_all(bus_all),
    .bus_alh(bus_alh), .bus_cs1(bus_cs1), .bus_cs2(bus_cs2)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic pin(input logic act, input logic pol);
    return act ? pol : ~pol;
  endfunction

  function automatic logic [15:0] mask_addr(input logic [15:0] a, input logic [1:0] cs);
    logic [15:0] m;
    m = a;
    if (cs[0]) m[14] = 1'b0;
    if (cs[1]) m[15] = 1'b0;
    return m;
  endfunction

  task automatic idle_check(input string tag);
    logic [6:0] e;
    e = {~c_pol[0], ~c_pol[1], ~c_pol[2], ~c_pol[3], ~c_pol[3], ~c_pol[4], ~c_pol[5]};
    chk({bus_rd, bus_wr, bus_be, bus_all, bus_alh, bus_cs1, bus_cs2} === e,
        "R1", {tag, " strobes"}, {bus_rd, bus_wr, bus_be, bus_all, bus_alh, bus_cs1, bus_cs2}, e);
    chk(busy === 0 && done === 0 && bus_oe === 0 && bus_dout === 0 &&
        bus_addr === 0 && rd_data === 0, "R1", {tag, " datapath"},
        {busy, done, bus_oe, bus_dout, bus_addr[7:0]}, 0);
  endtask

  task automatic run_xfer(input logic wr, input logic use_a, input logic [15:0] a,
                          input logic [15:0] wd, input logic poke);
    logic [15:0] eff, m, e_addr;
    logic [7:0]  dlo, dhi, e_dout;
    logic [6:0]  e_str;
    logic [1:0]  e_cs;
    logic        dph, a_rd, a_wr;
    int na, nd, k;
    string mlabel, alabel;
    eff = use_a ? a : ptr_m;
    m   = mask_addr(eff, c_cs);
    na  = (c_mux == 2'b01) ? 1 : (c_mux == 2'b10) ? 2 : 0;
    nd  = c_wide ? 2 : 1;
    mlabel = (na == 1) ? "R3" : (na == 2) ? "R4" : "R2";
    alabel = !use_a ? "R10" : (c_cs != 0) ? "R9" : mlabel;
    e_cs = {c_cs[1] & eff[15], c_cs[0] & eff[14]};
    dlo = 8'h00; dhi = 8'h00;
    req_valid = 1'b1; req_write = wr; req_use_addr = use_a; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = poke; req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
    for (int i = 0; i < na + nd; i++) begin
      k = (i < na) ? i : 2 + (i - na);
      bus_din = 8'($urandom);
      if (k == 2) dlo = bus_din;
      if (k == 3) dhi = bus_din;
      dph    = (k >= 2);
      e_dout = (k == 0) ? m[7:0] : (k == 1) ? m[15:8] :
               (wr ? ((k == 2) ? wd[7:0] : wd[15:8]) : 8'h00);
      e_addr = (na == 1) ? {m[15:8], 8'h00} : (na == 2) ? 16'h0000 : m;
      a_rd   = c_sep ? (dph && !wr) : !wr;
      a_wr   = c_sep ? (dph && wr) : dph;
      e_str  = {pin(a_rd, c_pol[0]), pin(a_wr, c_pol[1]), pin(k == 3, c_pol[2]),
                pin(k == 0, c_pol[3]), pin(k == 1, c_pol[3]),
                pin(e_cs[0], c_pol[4]), pin(e_cs[1], c_pol[5])};
      chk(bus_dout === e_dout, (k < 2) ? mlabel : (k == 3 ? "R5" : "R2"), "bus_dout", bus_dout, e_dout);
      chk(bus_oe === ((k < 2) || wr), "R11", "bus_oe", bus_oe, (k < 2) || wr);
      chk(bus_addr === e_addr, alabel, "bus_addr", bus_addr, e_addr);
      chk({bus_rd, bus_wr, bus_be, bus_all, bus_alh, bus_cs1, bus_cs2} === e_str, "R8",
          "control pins", {bus_rd, bus_wr, bus_be, bus_all, bus_alh, bus_cs1, bus_cs2}, e_str);
      chk({bus_rd, bus_wr} === e_str[6:5], c_sep ? "R6" : "R7", "rd/wr", {bus_rd, bus_wr}, e_str[6:5]);
      chk(bus_be === e_str[4], "R5", "bus_be", bus_be, e_str[4]);
      chk({bus_all, bus_alh} === e_str[3:2], mlabel, "latch strobes", {bus_all, bus_alh}, e_str[3:2]);
      chk({bus_cs2, bus_cs1} === {e_str[0], e_str[1]}, "R9", "chip selects",
          {bus_cs2, bus_cs1}, {e_str[0], e_str[1]});
      chk(busy === 1'b1 && done === 1'b0, "R12", "busy in phase", {busy, done}, 2'b10);
      if (i < na + nd - 1) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R12", "done pulse", {done, busy}, 2'b10);
    chk(bus_oe === 1'b0, "R11", "bus_oe idle", bus_oe, 0);
    if (!wr)
      chk(rd_data === {c_wide ? dhi : 8'h00, dlo}, c_wide ? "R5" : "R12", "rd_data",
          rd_data, {c_wide ? dhi : 8'h00, dlo});
    case (c_step)
      2'b01:   ptr_m = eff + 16'd1;
      2'b10:   ptr_m = eff - 16'd1;
      default: ptr_m = eff;
    endcase
    if (poke) begin
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R12", "request while busy ignored", {busy, done}, 0);
    end
  endtask

  task automatic set_cfg(input logic sep, input logic wide, input logic [1:0] mux,
                         input logic [1:0] step, input logic [1:0] cs, input logic [5:0] pol);
    c_sep = sep; c_wide = wide; c_mux = mux; c_step = step; c_cs = cs; c_pol = pol;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R12 watchdog expired actual=%h expected=%h", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst = 1'b1; req_valid = 0; req_write = 0; req_use_addr = 0;
    req_addr = 0; req_wdata = 0; bus_din = 0; ptr_m = 0;
    set_cfg(1, 0, 2'b00, 2'b00, 2'b00, 6'b101001);
    repeat (3) @(negedge clk);
    idle_check("in reset");
    rst = 1'b0;
    @(negedge clk);
    idle_check("after reset");

    // demultiplexed, separate strobes
    set_cfg(1, 0, 2'b00, 2'b00, 2'b00, 6'b111111);
    run_xfer(1, 1, 16'h1234, 16'h00A5, 0);
    run_xfer(0, 1, 16'h4321, 16'h0000, 0);
    // reserved code 11 acts as demultiplexed
    set_cfg(1, 1, 2'b11, 2'b00, 2'b00, 6'b111111);
    run_xfer(0, 1, 16'h0F0F, 16'h0000, 0);
    // partial multiplexing, 16-bit write
    set_cfg(1, 1, 2'b01, 2'b00, 2'b00, 6'b111111);
    run_xfer(1, 1, 16'hBEEF, 16'hC3D2, 0);
    // full multiplexing, 16-bit read, low-active pins
    set_cfg(1, 1, 2'b10, 2'b00, 2'b00, 6'b000000);
    run_xfer(0, 1, 16'h5A69, 16'h0000, 0);
    // combined direction/enable style
    set_cfg(0, 0, 2'b00, 2'b00, 2'b00, 6'b010101);
    run_xfer(0, 1, 16'h00C0, 16'h0000, 0);
    set_cfg(0, 1, 2'b10, 2'b00, 2'b00, 6'b101010);
    run_xfer(1, 1, 16'h0102, 16'hA1B2, 0);
    // chip selects with the top bits set
    set_cfg(1, 0, 2'b10, 2'b00, 2'b11, 6'b111111);
    run_xfer(0, 1, 16'hC0AA, 16'h0000, 0);
    set_cfg(1, 0, 2'b00, 2'b00, 2'b01, 6'b011111);
    run_xfer(1, 1, 16'h4001, 16'h0077, 0);
    // pointer stepping with wrap
    set_cfg(1, 0, 2'b00, 2'b01, 2'b00, 6'b111111);
    run_xfer(1, 1, 16'hFFFF, 16'h0011, 0);
    run_xfer(0, 0, 16'h0000, 16'h0000, 0);
    set_cfg(1, 0, 2'b00, 2'b10, 2'b00, 6'b111111);
    run_xfer(0, 0, 16'h0000, 16'h0000, 0);
    run_xfer(0, 0, 16'h0000, 16'h0000, 0);
    set_cfg(1, 0, 2'b00, 2'b11, 2'b00, 6'b111111);
    run_xfer(0, 0, 16'h0000, 16'h0000, 0);
    run_xfer(0, 0, 16'h0000, 16'h0000, 0);
    // requests during a transfer are ignored
    set_cfg(1, 1, 2'b10, 2'b01, 2'b00, 6'b111111);
    run_xfer(1, 1, 16'h2222, 16'h3333, 1);

    for (int t = 0; t < 300; t++) begin
      set_cfg(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
              2'($urandom), 6'($urandom));
      run_xfer(1'($urandom), $urandom_range(0, 3) != 0, 16'($urandom), 16'($urandom),
               $urandom_range(0, 7) == 0);
    end

    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule